// File: doc/BRIEF.md
# Sigma-Delta Converter Register Port (SPI Slave)

This block is the device-side serial register interface of a multi-channel sigma-delta converter. An SPI master reaches the converter's register file through it. Every transaction starts with an 8-bit command byte that carries a read flag and a 6-bit register address. Data bytes follow the command. Their count depends on the addressed register, and they travel most significant bit first. Several transactions may follow each other while chip-select stays low. Each new command byte begins right after the last data bit of the previous transaction.

The block works in one system clock domain. SCLK, chip-select and MOSI pass through a synchronizer, and edges are detected on the synchronized SCLK (mode 3: idle high, input captured on the rising edge, MISO updated on the falling edge). The conversion engine outside the block loads each 24-bit result, with the number of the channel that produced it, through a parallel result port. The block also models three more behaviours:
- a power-on flag in the status byte that clears after a settle time,
- a fixed identification byte,
- a software reset: a run of ones on MOSI returns the interface and every register to its default.

Top module: `sdreg_spi_slave`

## Requirements
- R1: Command bit 6 set means read and clear means write. Bits 5:0 are the register address. MOSI is captured on rising SCLK, MISO changes only on falling SCLK, and MISO is 0 while chip-select is high.
- R2: Data byte counts are:
  - 1 byte: addresses 0x00, 0x05 and 0x08.
  - 2 bytes: 0x01, 0x04, and 0x09 through 0x20.
  - 3 bytes: 0x02, 0x03, 0x06, 0x07, and 0x21 through 0x38.
  
  A following command in the same frame is decoded exactly after that many bytes.
- R3: A write to a writable address stores the data bytes, MSB first. A later read returns them unchanged.
- R4: A read of address 0 returns the status byte. Bit 4 is the power-on flag, bits 3:0 hold the last result's channel, and bits 7:5 are 0. A write command to address 0 carries no data, so the next byte is a new command.
- R5: 64 consecutive ones on MOSI while chip-select is low return every register to 0 and the interface to command decoding. A run of 63 ones followed by a zero does not.
- R6: The power-on flag is 1 after hard or software reset. It clears after SETTLE_CYC system clocks.
- R7: A read of address 0x05 returns DEV_ID in bits 7:4 and SIL_REV (nonzero) in bits 3:0.
- R8: When bit 10 of the 2-byte control register (0x01) is 1, a read of 0x02 returns the 3 data bytes followed by the status byte, 4 bytes in all.
- R9: A pulse on res_we loads res_data into register 0x02 and res_chan into the status channel field. A read of 0x02 returns the 24-bit result MSB first.
- R10: Addresses 0x39 to 0x3F are ignored. MISO stays 0 until chip-select rises, and no register changes.
- R11: Chip-select going high aborts a partial transaction without storing anything, and the next byte is decoded as a command.
- R12: Writes to 0x00, 0x02 and 0x05 store nothing, but their data bytes are still consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idle high |
| cs_n | input | 1 | Chip-select, active low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out, registered |
| res_we | input | 1 | Load a new conversion result |
| res_data | input | 24 | Conversion result |
| res_chan | input | 4 | Channel that produced the result |

## Verification
A wrong bit counter or width decode does not stay local. Within the same frame, the next command is read from the wrong bit position, so every later byte of a chained read comes back shifted or zero. Chained frames that mix 1-, 2- and 3-byte registers therefore expose a width error in the same frame. An unwanted write or a missed reset only shows on a later read-back. Because of that, every stimulus that must have no effect is followed by a read of the register it could have touched. Power-on flag timing is checked by reading the status byte once inside the settle window and once after it.

// File: rtl/sdreg_pkg.sv
package sdreg_pkg;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 24;
  localparam int MEM_D      = 1 << ADDR_W;
  localparam int APPEND_BIT = 10;
  localparam logic [ADDR_W-1:0] A_STATUS = 6'h00;
  localparam logic [ADDR_W-1:0] A_CTRL   = 6'h01;
  localparam logic [ADDR_W-1:0] A_DATA   = 6'h02;
  localparam logic [ADDR_W-1:0] A_ID     = 6'h05;
  localparam logic [ADDR_W-1:0] A_LAST   = 6'h38;

  typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD, ST_SKIP} spi_st_e;

  function automatic logic [1:0] reg_bytes(input logic [ADDR_W-1:0] a);
    if (a == 6'h00 || a == 6'h05 || a == 6'h08) return 2'd1;
    if (a == 6'h01 || a == 6'h04)               return 2'd2;
    if (a <= 6'h07)                             return 2'd3;
    if (a <= 6'h20)                             return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic addr_ok(input logic [ADDR_W-1:0] a);
    return a <= A_LAST;
  endfunction

  function automatic logic addr_wr(input logic [ADDR_W-1:0] a);
    return addr_ok(a) && a != A_STATUS && a != A_DATA && a != A_ID;
  endfunction
endpackage

// File: rtl/sdreg_sync.sv
module sdreg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '1;
        else     pipe[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '1;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sdreg_ones_det.sv
module sdreg_ones_det #(
  parameter int RUN = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bit_rise,
  input  logic bit_val,
  output logic pulse
);
  localparam int CW = $clog2(RUN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (bit_rise) begin
        if (!bit_val) begin
          cnt <= '0;
        end else if (cnt == CW'(RUN - 1)) begin
          cnt   <= '0;
          pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_RUN_PULSE: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(bit_rise && bit_val)); // R5
endmodule

// File: rtl/sdreg_por.sv
module sdreg_por #(
  parameter int SETTLE = 200000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic flag
);
  localparam int CW = $clog2(SETTLE + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || kick) begin
      flag <= 1'b1;
      cnt  <= '0;
    end else if (flag) begin
      if (cnt == CW'(SETTLE - 1)) flag <= 1'b0;
      else                        cnt  <= cnt + 1'b1;
    end
  end

  AST_POR_KICK: assert property (@(posedge clk) disable iff (rst)
    kick |=> flag); // R6
endmodule

// File: rtl/sdreg_regfile.sv
module sdreg_regfile import sdreg_pkg::*; #(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          res_we,
  input  logic [DW-1:0] res_data,
  input  logic [3:0]    res_chan,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          append_en,
  output logic [3:0]    last_chan
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      last_chan <= '0;
    end else begin
      if (wr_en) mem[wr_addr] <= wr_data;
      if (res_we) begin
        mem[A_DATA] <= res_data;
        last_chan   <= res_chan;
      end
    end
  end

  assign rd_data   = mem[rd_addr];
  assign append_en = mem[A_CTRL][APPEND_BIT];

  AST_DATA_RO: assert property (@(posedge clk) disable iff (rst)
    (!res_we && !clr) |=> $stable(mem[A_DATA])); // R12
  AST_WR_LEGAL: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> addr_wr(wr_addr)); // R12
endmodule

// File: rtl/sdreg_spi_slave.sv
module sdreg_spi_slave import sdreg_pkg::*; #(
  parameter int         SYNC_STAGES = 2,
  parameter int         RST_ONES    = 64,
  parameter int         SETTLE_CYC  = 200000,
  parameter logic [3:0] DEV_ID      = 4'h3,
  parameter logic [3:0] SIL_REV     = 4'h2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  input  logic        res_we,
  input  logic [23:0] res_data,
  input  logic [3:0]  res_chan
);
  logic sclk_s, cs_idle, mosi_s, sclk_d;
  logic rise, fall, soft_rst, por_flag, append_en;
  logic [3:0] last_chan;
  logic [DATA_W-1:0] rf_rdata;

  sdreg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({sclk, cs_n, mosi}), .q({sclk_s, cs_idle, mosi_s}));

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b1;
    else     sclk_d <= sclk_s;
  end

  assign rise = sclk_s && !sclk_d && !cs_idle;
  assign fall = !sclk_s && sclk_d && !cs_idle;

  sdreg_ones_det #(.RUN(RST_ONES)) u_ones (
    .clk(clk), .rst(rst), .clr(cs_idle), .bit_rise(rise), .bit_val(mosi_s), .pulse(soft_rst));

  sdreg_por #(.SETTLE(SETTLE_CYC)) u_por (
    .clk(clk), .rst(rst), .kick(soft_rst), .flag(por_flag));

  spi_st_e            st;
  logic [5:0]         cmd_sh;
  logic [22:0]        wr_sh;
  logic [31:0]        rd_sh;
  logic [5:0]         bitcnt, nbits;
  logic [ADDR_W-1:0]  cur_addr;
  logic               miso_q;
  logic               wr_en;
  logic [ADDR_W-1:0]  wr_addr;
  logic [DATA_W-1:0]  wr_data;

  logic [6:0]         cmd_full;
  logic [ADDR_W-1:0]  cmd_addr;
  logic [7:0]         status_b;
  logic [DATA_W-1:0]  rd_word;
  logic [1:0]         rd_bytes;
  logic [31:0]        rd_load;
  logic [5:0]         rd_len;

  assign cmd_full = {cmd_sh, mosi_s};
  assign cmd_addr = cmd_full[ADDR_W-1:0];
  assign status_b = {3'b000, por_flag, last_chan};
  assign rd_bytes = reg_bytes(cmd_addr);

  sdreg_regfile u_rf (
    .clk(clk), .rst(rst), .clr(soft_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .res_we(res_we), .res_data(res_data), .res_chan(res_chan),
    .rd_addr(cmd_addr), .rd_data(rf_rdata),
    .append_en(append_en), .last_chan(last_chan));

  always_comb begin
    case (cmd_addr)
      A_STATUS: rd_word = {16'h0, status_b};
      A_ID:     rd_word = {16'h0, DEV_ID, SIL_REV};
      default:  rd_word = rf_rdata;
    endcase
    if (cmd_addr == A_DATA && append_en) begin
      rd_load = {rd_word, status_b};
      rd_len  = 6'd32;
    end else begin
      rd_len = {1'b0, rd_bytes, 3'b000};
      case (rd_bytes)
        2'd1:    rd_load = {rd_word[7:0], 24'h0};
        2'd2:    rd_load = {rd_word[15:0], 16'h0};
        default: rd_load = {rd_word, 8'h0};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst || cs_idle) begin
      st       <= ST_CMD;
      bitcnt   <= '0;
      cmd_sh   <= '0;
      wr_sh    <= '0;
      rd_sh    <= '0;
      nbits    <= '0;
      cur_addr <= '0;
      miso_q   <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (rise) begin
        bitcnt <= bitcnt + 6'd1;
        case (st)
          ST_CMD: begin
            cmd_sh <= cmd_full[5:0];
            if (bitcnt == 6'd7) begin
              bitcnt <= '0;
              if (!addr_ok(cmd_addr)) begin
                st <= ST_SKIP;
              end else if (cmd_full[6]) begin
                st    <= ST_RD;
                rd_sh <= rd_load;
                nbits <= rd_len;
              end else if (cmd_addr != A_STATUS) begin
                st       <= ST_WR;
                cur_addr <= cmd_addr;
                nbits    <= {1'b0, rd_bytes, 3'b000};
                wr_sh    <= '0;
              end
            end
          end
          ST_WR: begin
            wr_sh <= {wr_sh[21:0], mosi_s};
            if (bitcnt == nbits - 6'd1) begin
              bitcnt  <= '0;
              st      <= ST_CMD;
              wr_en   <= addr_wr(cur_addr);
              wr_addr <= cur_addr;
              wr_data <= {wr_sh, mosi_s};
            end
          end
          ST_RD: begin
            if (bitcnt == nbits - 6'd1) begin
              bitcnt <= '0;
              st     <= ST_CMD;
            end
          end
          default: bitcnt <= '0;
        endcase
      end else if (fall) begin
        if (st == ST_RD) begin
          miso_q <= rd_sh[31];
          rd_sh  <= {rd_sh[30:0], 1'b0};
        end else begin
          miso_q <= 1'b0;
        end
      end
    end
  end

  assign miso = miso_q;

  AST_CS_ABORT: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> (st == ST_CMD && bitcnt == 6'd0 && !miso_q)); // R11
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SKIP) |-> !miso_q); // R10
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RD) |-> !wr_en); // R3
endmodule

// File: tb/test_sdreg_spi_slave.sv
module test_sdreg_spi_slave;
  localparam int H      = 8;
  localparam int SETTLE = 600;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1, cs_n = 1'b1, mosi = 1'b1;
  logic miso;
  logic res_we = 1'b0;
  logic [23:0] res_data = '0;
  logic [3:0]  res_chan = '0;

  always #5 clk = ~clk;

  sdreg_spi_slave #(.SETTLE_CYC(SETTLE)) i_sdreg_spi_slave (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .res_we(res_we), .res_data(res_data), .res_chan(res_chan));

  int vectors = 0, errors = 0;
  bit done = 1'b0;

  logic [7:0] tx_buf [64];
  int         tx_n = 0;
  logic [7:0] exp_val_q [$];
  bit         exp_care_q [$];
  string      exp_tag_q [$];
  logic [7:0] act_q [$];

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver side: queue one byte and its expectation
  task automatic put(input logic [7:0] tx, input bit care, input logic [7:0] ev, input string tag);
    tx_buf[tx_n] = tx;
    tx_n++;
    exp_val_q.push_back(ev);
    exp_care_q.push_back(care);
    exp_tag_q.push_back(tag);
  endtask

  task automatic wr_reg(input logic [5:0] a, input int n, input logic [23:0] v, input string tag);
    put({2'b00, a}, 1'b0, 8'h00, tag);
    for (int i = n - 1; i >= 0; i--) put(v[8*i +: 8], 1'b0, 8'h00, tag);
  endtask

  task automatic rd_reg(input logic [5:0] a, input int n, input logic [31:0] v, input string tag);
    put({2'b01, a}, 1'b0, 8'h00, tag);
    for (int i = n - 1; i >= 0; i--) put(8'h00, 1'b1, v[8*i +: 8], tag);
  endtask

  task automatic run_frame();
    logic [7:0] r;
    @(negedge clk) cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int b = 0; b < tx_n; b++) begin
      r = '0;
      for (int i = 7; i >= 0; i--) begin
        sclk = 1'b0;
        mosi = tx_buf[b][i];
        repeat (H) @(negedge clk);
        r = {r[6:0], miso};
        sclk = 1'b1;
        repeat (H) @(negedge clk);
      end
      act_q.push_back(r);
    end
    cs_n = 1'b1;
    mosi = 1'b1;
    tx_n = 0;
    repeat (2 * H) @(negedge clk);
  endtask

  // monitor: pops received bytes and compares with expectations
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0) begin
        logic [7:0] a, e;
        bit c;
        string t;
        a = act_q.pop_front();
        e = exp_val_q.pop_front();
        c = exp_care_q.pop_front();
        t = exp_tag_q.pop_front();
        if (c) check(t, {24'h0, a}, {24'h0, e});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 miso idle after reset", {31'h0, miso}, 32'h0);

    rd_reg(6'h00, 1, 32'h10, "R6 R4 status after power-on");
    run_frame();
    rd_reg(6'h05, 1, 32'h32, "R7 identification byte");
    run_frame();
    repeat (SETTLE + 100) @(negedge clk);
    rd_reg(6'h00, 1, 32'h00, "R6 status after settle");
    run_frame();

    // R2 R3: one write frame across widths, then one chained read frame
    wr_reg(6'h09, 2, 24'h1234,   "R3 w09");
    wr_reg(6'h21, 3, 24'hABCDEF, "R3 w21");
    wr_reg(6'h08, 1, 24'h5A,     "R3 w08");
    wr_reg(6'h03, 3, 24'h010203, "R3 w03");
    wr_reg(6'h04, 2, 24'hBEEF,   "R3 w04");
    wr_reg(6'h38, 3, 24'h0F0E0D, "R3 w38");
    wr_reg(6'h20, 2, 24'h7788,   "R3 w20");
    run_frame();
    rd_reg(6'h09, 2, 32'h1234,   "R2 R3 read 0x09");
    rd_reg(6'h21, 3, 32'hABCDEF, "R2 R3 read 0x21");
    rd_reg(6'h08, 1, 32'h5A,     "R2 R3 read 0x08");
    rd_reg(6'h03, 3, 32'h010203, "R2 R3 read 0x03");
    rd_reg(6'h04, 2, 32'hBEEF,   "R2 R3 read 0x04");
    rd_reg(6'h38, 3, 32'h0F0E0D, "R2 R3 read 0x38");
    rd_reg(6'h20, 2, 32'h7788,   "R2 R3 read 0x20");
    run_frame();

    // R4: write command to address 0 carries no data
    put(8'h00, 1'b0, 8'h00, "R4 write addr0");
    rd_reg(6'h09, 2, 32'h1234, "R4 command after write addr0");
    run_frame();

    // R10: invalid addresses
    wr_reg(6'h39, 2, 24'hFFFF, "R10 w39");
    run_frame();
    rd_reg(6'h3A, 2, 32'h0000, "R10 read 0x3A gives zeros");
    run_frame();
    rd_reg(6'h09, 2, 32'h1234, "R10 register unchanged");
    run_frame();

    // R11: partial write aborted by chip-select
    put(8'h09, 1'b0, 8'h00, "R11 partial");
    put(8'h77, 1'b0, 8'h00, "R11 partial");
    run_frame();
    rd_reg(6'h09, 2, 32'h1234, "R11 abort stores nothing");
    run_frame();

    // R12: read-only targets
    wr_reg(6'h05, 1, 24'hFF, "R12 w05");
    wr_reg(6'h02, 3, 24'h010203, "R12 w02");
    rd_reg(6'h05, 1, 32'h32, "R12 id unchanged");
    rd_reg(6'h02, 3, 32'h000000, "R12 data unchanged");
    run_frame();

    // R9: conversion result load
    @(negedge clk);
    res_data = 24'hA5B6C7;
    res_chan = 4'h5;
    res_we   = 1'b1;
    @(negedge clk) res_we = 1'b0;
    rd_reg(6'h02, 3, 32'hA5B6C7, "R9 result big-endian");
    rd_reg(6'h00, 1, 32'h05, "R9 R4 status channel");
    run_frame();

    // R8: status append
    wr_reg(6'h01, 2, 24'h0400, "R8 set append");
    run_frame();
    rd_reg(6'h01, 2, 32'h0400, "R8 control read");
    rd_reg(6'h02, 4, 32'hA5B6C705, "R8 data plus status");
    rd_reg(6'h09, 2, 32'h1234, "R8 alignment after append");
    run_frame();

    // R5 boundary: 63 ones then a zero does not reset
    for (int i = 0; i < 7; i++) put(8'hFF, 1'b0, 8'h00, "R5 63 ones");
    put(8'hFE, 1'b0, 8'h00, "R5 63 ones");
    run_frame();
    rd_reg(6'h09, 2, 32'h1234, "R5 no reset after 63 ones");
    run_frame();

    // R5: 64 ones reset everything
    for (int i = 0; i < 8; i++) put(8'hFF, 1'b0, 8'h00, "R5 64 ones");
    run_frame();
    rd_reg(6'h00, 1, 32'h10, "R5 R6 status after soft reset");
    rd_reg(6'h09, 2, 32'h0000, "R5 reg cleared");
    rd_reg(6'h01, 2, 32'h0000, "R5 control cleared");
    rd_reg(6'h02, 3, 32'h000000, "R5 data cleared, no append");
    run_frame();
    repeat (SETTLE + 100) @(negedge clk);
    rd_reg(6'h00, 1, 32'h00, "R6 flag clears after soft reset");
    run_frame();
    check("R1 miso idle at end", {31'h0, miso}, 32'h0);

    repeat (4) @(negedge clk);
    while (act_q.size() > 0) @(negedge clk);
    summary();
  end
endmodule